// File: doc/BRIEF.md
# Endpoint-Zero Control/Status Register

This block keeps the eight status and command bits of a control endpoint on a USB-style device. Two parties update it. Software uses a simple register port with a write strobe, a read strobe and a 32-bit data word, of which only the low byte is used. A packet engine sends single-cycle event pulses into it. The events are: a packet was received, an IN packet was transmitted, a STALL handshake went out, and the control transaction ended.

From these inputs the block keeps a set of flags. Some flags are set by hardware and cleared by write-one commands. Some are set by software and cleared by hardware. One is set by hardware and cleared only by software. From the flags it drives a stall request to the engine, a one-cycle FIFO flush pulse when a transfer is cut short, and a one-cycle interrupt pulse gated by an enable input. Reads return the flags combinationally while the read strobe is high.

Bit layout of the low byte:

| Bit | Meaning |
|-----|---------|
| 0 | packet received |
| 1 | IN packet ready |
| 2 | stall sent |
| 3 | data end |
| 4 | setup end |
| 5 | send stall |
| 6 | write 1 to clear "packet received" |
| 7 | write 1 to clear "setup end" |

Top module: `ep0_csr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register bit is 0, and irq, fifo_flush and stall_req are 0.
- R2: A received-packet event sets bit 0. A write with bit 6 at 1 clears bit 0. Bit 6 always reads as 0.
- R3: A write with bit 1 at 1 sets bit 1. A transmit-done event while bit 1 is set clears it and raises an interrupt.
- R4: A write with bit 5 at 1 sets bit 5, and stall_req follows bit 5. A stall-sent event clears bit 5 and sets bit 2.
- R5: Bit 2 is cleared only by a write that has bit 2 at 0. A write that has bit 2 at 1 leaves it set. Setting bit 2 raises an interrupt.
- R6: A write with bit 3 at 1 sets bit 3. A transaction-end event while bit 3 is set clears bit 3, leaves bit 4 at 0, and gives no flush pulse and no interrupt.
- R7: A transaction-end event while bit 3 is clear sets bit 4, raises an interrupt, and gives a fifo_flush pulse exactly one cycle long.
- R8: A write with bit 7 at 1 clears bit 4. Bit 7 always reads as 0.
- R9: If a hardware event that sets bit 0, bit 2 or bit 4 lands in the same cycle as a software write that clears that bit, the bit ends up set.
- R10: Bits 31:8 read as 0 and ignore writes. Writing 1 to bit 0 or bit 4 has no effect.
- R11: irq is high for exactly one cycle. It rises in the cycle after the triggering event only if irq_en was high in the event cycle.
- R12: sw_rd_data is 0 whenever sw_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_en | input | 1 | Software read strobe |
| sw_rd_data | output | 32 | Register value while reading, else 0 |
| ev_rx_pkt | input | 1 | Engine: packet received |
| ev_tx_done | input | 1 | Engine: IN packet transmitted |
| ev_stall_sent | input | 1 | Engine: STALL handshake sent |
| ev_xfer_end | input | 1 | Engine: control transaction ended |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle interrupt pulse |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| stall_req | output | 1 | Request to the engine to answer with STALL |

## Verification
A software clear and a hardware set can arrive at the same flag in the same clock cycle. This is the collision that matters most here. The bench provokes it for three flags by asserting a set event in the same cycle as a write:
- a received-packet event together with the bit-6 command;
- a transaction-end event together with the bit-7 command;
- a stall-sent event together with a write that has bit 2 at 0.

After that edge, each flag must read back as 1. The interrupt pulse from the event must also appear, which shows the write did not hide the event.

// File: rtl/ep0_csr_pkg.sv
// Package: bit positions and bundle types shared by the endpoint-zero
// status logic. Bit positions are fixed because software decodes them.
package ep0_csr_pkg;

    localparam int CSR_W   = 8;
    localparam int B_RX    = 0;  // packet received (hardware set)
    localparam int B_INRDY = 1;  // IN packet ready (software set)
    localparam int B_STDN  = 2;  // stall sent (hardware set)
    localparam int B_DEND  = 3;  // data end (software set)
    localparam int B_SEND  = 4;  // setup end (hardware set)
    localparam int B_STRQ  = 5;  // send stall (software set)
    localparam int B_CLRRX = 6;  // command: clear packet received
    localparam int B_CLRSE = 7;  // command: clear setup end

    // Event pulses coming from the packet engine.
    typedef struct packed {
        logic rx_pkt;
        logic tx_done;
        logic stall_sent;
        logic xfer_end;
    } ep0_evt_t;

    // Decoded software write actions.
    typedef struct packed {
        logic set_inrdy;
        logic set_dend;
        logic set_strq;
        logic clr_rx;
        logic clr_se;
        logic clr_stdn;
    } ep0_cmd_t;

    // Interrupt sources, one bit per reason.
    typedef struct packed {
        logic rx_set;
        logic in_done;
        logic stdn_set;
        logic se_set;
    } ep0_src_t;

endpackage

// File: rtl/ep0_cmd_decode.sv
// Module: ep0_cmd_decode
// Turns one software write into set and clear actions for the flag bank.
// Assumes the write strobe lasts one cycle per access. Bits above the
// command byte and the read-only positions in it are ignored.
module ep0_cmd_decode
    import ep0_csr_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output ep0_cmd_t         cmd
);

    localparam int HI_W = BUS_W - CSR_W;

    // Absorb the bits that carry no command.
    logic unused_bits;
    assign unused_bits = ^{wr_data[BUS_W-1:CSR_W], wr_data[B_RX], wr_data[B_SEND]};

    // Decode the command byte while the strobe is high.
    always_comb begin
        cmd           = '0;
        if (wr_en) begin
            cmd.set_inrdy = wr_data[B_INRDY];
            cmd.set_dend  = wr_data[B_DEND];
            cmd.set_strq  = wr_data[B_STRQ];
            cmd.clr_rx    = wr_data[B_CLRRX];
            cmd.clr_se    = wr_data[B_CLRSE];
            cmd.clr_stdn  = ~wr_data[B_STDN];
        end
    end

    // Elaboration guard: the bus must be wider than the command byte.
    if (HI_W < 1) begin : g_bad_width
        initial $display("ep0_cmd_decode: BUS_W must exceed %0d", CSR_W);
    end

endmodule

// File: rtl/ep0_flag_bank.sv
// Module: ep0_flag_bank
// Holds the six status flags and applies engine events and software
// actions to them. A hardware set beats a software clear in the same
// cycle. Setup end is decided from the data-end value held before the edge.
module ep0_flag_bank
    import ep0_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ep0_evt_t          evt,
    input  ep0_cmd_t          cmd,
    output logic [CSR_W-1:0]  csr,
    output ep0_src_t          src
);

    logic rx_q, inrdy_q, stdn_q, dend_q, se_q, strq_q;
    logic rx_d, inrdy_d, stdn_d, dend_d, se_d, strq_d;
    logic se_ev;

    // A transfer that ends without data end is a premature end.
    assign se_ev = evt.xfer_end & ~dend_q;

    // Next-state rules for every flag.
    always_comb begin
        rx_d    = evt.rx_pkt     | (rx_q    & ~cmd.clr_rx);
        stdn_d  = evt.stall_sent | (stdn_q  & ~cmd.clr_stdn);
        se_d    = se_ev          | (se_q    & ~cmd.clr_se);
        inrdy_d = cmd.set_inrdy  | (inrdy_q & ~evt.tx_done);
        dend_d  = cmd.set_dend   | (dend_q  & ~evt.xfer_end);
        strq_d  = cmd.set_strq   | (strq_q  & ~evt.stall_sent);
    end

    // Flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q    <= 1'b0;
            inrdy_q <= 1'b0;
            stdn_q  <= 1'b0;
            dend_q  <= 1'b0;
            se_q    <= 1'b0;
            strq_q  <= 1'b0;
        end else begin
            rx_q    <= rx_d;
            inrdy_q <= inrdy_d;
            stdn_q  <= stdn_d;
            dend_q  <= dend_d;
            se_q    <= se_d;
            strq_q  <= strq_d;
        end
    end

    // Assemble the readable byte; command positions read as zero.
    always_comb begin
        csr          = '0;
        csr[B_RX]    = rx_q;
        csr[B_INRDY] = inrdy_q;
        csr[B_STDN]  = stdn_q;
        csr[B_DEND]  = dend_q;
        csr[B_SEND]  = se_q;
        csr[B_STRQ]  = strq_q;
    end

    // Report the reasons for an interrupt in this cycle.
    always_comb begin
        src.rx_set   = evt.rx_pkt;
        src.in_done  = evt.tx_done & inrdy_q;
        src.stdn_set = evt.stall_sent;
        src.se_set   = se_ev;
    end

    logic p_rx, p_stall, p_setstrq, p_end, p_setdend, p_clrse;
    assign p_rx      = evt.rx_pkt;
    assign p_stall   = evt.stall_sent;
    assign p_setstrq = cmd.set_strq;
    assign p_end     = evt.xfer_end;
    assign p_setdend = cmd.set_dend;
    assign p_clrse   = cmd.clr_se;

    // R9: a received packet leaves the flag set whatever software wrote
    a_r9_rx_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(p_rx) |-> rx_q);

    // R4: stall sent drops the request and raises the sent flag
    a_r4_stall_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(p_stall) && !$past(p_setstrq) |-> !strq_q && stdn_q);

    // R8: setup end holds until the clear command
    a_r8_se_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(se_q) && !$past(p_clrse) |-> se_q);

    // R6: data end is consumed by the end of the transfer
    a_r6_dend_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dend_q) && $past(p_end) && !$past(p_setdend) |-> !dend_q);

endmodule

// File: rtl/ep0_pulse_gen.sv
// Module: ep0_pulse_gen
// Registers the interrupt and flush pulses one cycle after their cause.
// Assumes the sources are single-cycle pulses from the flag bank.
module ep0_pulse_gen
    import ep0_csr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     irq_en,
    input  ep0_src_t src,
    output logic     irq,
    output logic     fifo_flush
);

    logic any_src;
    assign any_src = |src;

    // Capture one-cycle pulses from this cycle's sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            fifo_flush <= 1'b0;
        end else begin
            irq        <= irq_en & any_src;
            fifo_flush <= src.se_set;
        end
    end

    // R11: an interrupt pulse needs the enable in the cause cycle
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

endmodule

// File: rtl/ep0_csr_ctrl.sv
// Module: ep0_csr_ctrl (top)
// Control endpoint status register. Connects the write decoder, the flag
// bank and the pulse generator, and serves reads combinationally.
// Assumes a single-cycle read and write strobe and single-cycle events.
module ep0_csr_ctrl
    import ep0_csr_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [BUS_W-1:0] sw_wr_data,
    input  logic             sw_rd_en,
    output logic [BUS_W-1:0] sw_rd_data,
    input  logic             ev_rx_pkt,
    input  logic             ev_tx_done,
    input  logic             ev_stall_sent,
    input  logic             ev_xfer_end,
    input  logic             irq_en,
    output logic             irq,
    output logic             fifo_flush,
    output logic             stall_req
);

    localparam int PAD_W = BUS_W - CSR_W;

    ep0_evt_t         evt;
    ep0_cmd_t         cmd;
    ep0_src_t         src;
    logic [CSR_W-1:0] csr;

    // Bundle the engine pulses.
    always_comb begin
        evt.rx_pkt     = ev_rx_pkt;
        evt.tx_done    = ev_tx_done;
        evt.stall_sent = ev_stall_sent;
        evt.xfer_end   = ev_xfer_end;
    end

    ep0_cmd_decode #(.BUS_W(BUS_W)) u_dec (
        .wr_en   (sw_wr_en),
        .wr_data (sw_wr_data),
        .cmd     (cmd)
    );

    ep0_flag_bank u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .cmd   (cmd),
        .csr   (csr),
        .src   (src)
    );

    ep0_pulse_gen u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_en     (irq_en),
        .src        (src),
        .irq        (irq),
        .fifo_flush (fifo_flush)
    );

    // Drive the register onto the read bus only during a read.
    always_comb begin
        sw_rd_data = '0;
        if (sw_rd_en) sw_rd_data = {{PAD_W{1'b0}}, csr};
    end

    assign stall_req = csr[B_STRQ];

    // R7: a flush pulse always comes with the setup-end flag
    a_r7_flush_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> csr[B_SEND]);

    // R12: nothing on the read bus without a read strobe
    a_r12_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rd_en |-> sw_rd_data == '0);

endmodule

// File: tb/ep0_csr_ctrl_bench.sv
module ep0_csr_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic        sw_rd_en = 1'b0;
    logic [31:0] sw_rd_data;
    logic        ev_rx_pkt = 1'b0, ev_tx_done = 1'b0;
    logic        ev_stall_sent = 1'b0, ev_xfer_end = 1'b0;
    logic        irq_en = 1'b1;
    logic        irq, fifo_flush, stall_req;

    int applied = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ep0_csr_ctrl u_ep0_csr_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .sw_rd_en(sw_rd_en), .sw_rd_data(sw_rd_data),
        .ev_rx_pkt(ev_rx_pkt), .ev_tx_done(ev_tx_done),
        .ev_stall_sent(ev_stall_sent), .ev_xfer_end(ev_xfer_end),
        .irq_en(irq_en), .irq(irq), .fifo_flush(fifo_flush),
        .stall_req(stall_req)
    );

    localparam logic [3:0] E_NONE = 4'b0000, E_RX = 4'b0001, E_TX = 4'b0010,
                           E_STL = 4'b0100, E_END = 4'b1000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one cycle of write and events from a falling edge to the next.
    task automatic step(input logic w, input logic [31:0] d, input logic [3:0] ev);
        sw_wr_en = w;
        sw_wr_data = d;
        {ev_xfer_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = ev;
        @(negedge clk);
        sw_wr_en = 1'b0;
        sw_wr_data = '0;
        {ev_xfer_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = E_NONE;
    endtask

    task automatic rd(output logic [31:0] v);
        sw_rd_en = 1'b1;
        #1;
        v = sw_rd_data;
        sw_rd_en = 1'b0;
        #1;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R12 idle bus", sw_rd_data, 32'h0);
        rd(v);
        chk("R1 reg", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 flush", {31'b0, fifo_flush}, 32'h0);
        chk("R1 stall_req", {31'b0, stall_req}, 32'h0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        step(1'b0, 0, E_RX);
        chk("R2 irq", {31'b0, irq}, 32'h1);
        rd(v);
        chk("R2 set", v, 32'h01);
        step(1'b0, 0, E_NONE);
        chk("R11 pulse ends", {31'b0, irq}, 32'h0);
        step(1'b1, 32'h40, E_NONE);
        rd(v);
        chk("R2 cleared, bit6 reads 0", v, 32'h00);
    endtask

    task automatic t_inrdy();
        logic [31:0] v;
        step(1'b1, 32'h02, E_NONE);
        rd(v);
        chk("R3 set", v, 32'h02);
        chk("R3 no irq on set", {31'b0, irq}, 32'h0);
        step(1'b0, 0, E_TX);
        chk("R3 irq", {31'b0, irq}, 32'h1);
        rd(v);
        chk("R3 cleared", v, 32'h00);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        step(1'b1, 32'h20, E_NONE);
        chk("R4 stall_req", {31'b0, stall_req}, 32'h1);
        rd(v);
        chk("R4 set", v, 32'h20);
        step(1'b0, 0, E_STL);
        chk("R4 stall_req drop", {31'b0, stall_req}, 32'h0);
        chk("R5 irq", {31'b0, irq}, 32'h1);
        rd(v);
        chk("R4 sent flag", v, 32'h04);
        step(1'b1, 32'h04, E_NONE);
        rd(v);
        chk("R5 write 1 keeps", v, 32'h04);
        step(1'b1, 32'h00, E_NONE);
        rd(v);
        chk("R5 write 0 clears", v, 32'h00);
    endtask

    task automatic t_dataend();
        logic [31:0] v;
        step(1'b1, 32'h08, E_NONE);
        rd(v);
        chk("R6 set", v, 32'h08);
        step(1'b0, 0, E_END);
        chk("R6 no flush", {31'b0, fifo_flush}, 32'h0);
        chk("R6 no irq", {31'b0, irq}, 32'h0);
        rd(v);
        chk("R6 cleared, no setup end", v, 32'h00);
    endtask

    task automatic t_setupend();
        logic [31:0] v;
        step(1'b0, 0, E_END);
        chk("R7 flush", {31'b0, fifo_flush}, 32'h1);
        chk("R7 irq", {31'b0, irq}, 32'h1);
        rd(v);
        chk("R7 set", v, 32'h10);
        step(1'b0, 0, E_NONE);
        chk("R7 flush one cycle", {31'b0, fifo_flush}, 32'h0);
        step(1'b1, 32'h80, E_NONE);
        rd(v);
        chk("R8 cleared, bit7 reads 0", v, 32'h00);
    endtask

    task automatic t_race();
        logic [31:0] v;
        step(1'b1, 32'h44, E_RX);
        chk("R9 rx irq", {31'b0, irq}, 32'h1);
        rd(v);
        chk("R9 rx wins", v, 32'h01);
        step(1'b1, 32'h84, E_END);
        chk("R9 setup end irq", {31'b0, irq}, 32'h1);
        rd(v);
        chk("R9 setup end wins", v, 32'h11);
        step(1'b1, 32'h00, E_STL);
        rd(v);
        chk("R9 stall sent wins", v, 32'h15);
        step(1'b1, 32'hC0, E_NONE);
        rd(v);
        chk("R9 cleanup", v, 32'h00);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        step(1'b1, 32'hFFFF_FF11, E_NONE);
        rd(v);
        chk("R10 upper and RO bits ignored", v, 32'h00);
        chk("R12 idle bus after read", sw_rd_data, 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        irq_en = 1'b0;
        step(1'b0, 0, E_RX);
        chk("R11 gated irq", {31'b0, irq}, 32'h0);
        rd(v);
        chk("R11 flag still set", v, 32'h01);
        irq_en = 1'b1;
        step(1'b1, 32'h40, E_NONE);
        chk("R11 no late irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx();
        t_inrdy();
        t_stall();
        t_dataend();
        t_setupend();
        t_race();
        t_reserved();
        t_gate();
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        applied++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

endmodule